// File: doc/BRIEF.md
# Page Write Collector and Committer

This block sits behind a two-wire serial memory front end and turns one write transaction into one page-wide update of a byte-wide synchronous memory. When a transaction opens, the block records the page that holds the start address and reads that whole page from memory into a local buffer. Data bytes then overwrite buffer slots starting at the start offset. Only the low offset bits advance, so a long burst wraps inside the same page and the newest byte in each slot wins.

When the transaction closes, the block checks the lock input once. If the lock is clear and at least one data byte arrived, the block writes every byte of the page back to memory in ascending order. Untouched slots therefore get their old contents back. A hold flag then stays high for a fixed number of cycles, which stands in for the self-timed programming time. While the flag is high, new transactions are refused. A locked close, or a close with no data bytes, ends the transaction with no memory write and no hold time.

Top module: `page_commit_unit`

## Requirements
- R1: After reset, `busy`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: An accepted `txn_open` starts a preload. The preload issues one read per cycle for the 32 addresses of the page containing `txn_addr` (page = `txn_addr[12:5]`), at offsets 0 to 31 in ascending order. The Nth data byte lands in slot `(txn_addr[4:0] + N) mod 32` of that page and never spills into the next page.
- R3: When more than 32 bytes arrive in one transaction, each slot ends up holding the last byte written to it.
- R4: No memory write occurs before `txn_close` for the current transaction has been seen.
- R5: A commit writes all 32 bytes of the page in 32 consecutive cycles, at offsets 0 to 31 in order. Each slot that received no data byte is written back with its preloaded value.
- R6: The lock input is sampled only in the cycle `txn_close` is high. If it is high then, the transaction produces no memory write and `busy` stays low. A change of the lock after that cycle does not alter the outcome.
- R7: A transaction closed without any data byte causes no memory write and no `busy` period.
- R8: `busy` rises in the same cycle as the first commit write and stays high for exactly `HOLD_CYCLES` cycles. Memory writes occur only while `busy` is high.
- R9: While `busy` is high, `txn_open`, `din_vld` and `txn_close` are ignored: no read, no write and no buffer change results from them.
- R10: A `txn_close` that arrives while the preload is still running is held until the preload ends. A data byte received during the preload takes priority over the preloaded value for its slot.
- R11: `mem_rd_en` and `mem_wr_en` are never high in the same cycle, and no read is issued while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_open | input | 1 | One-cycle strobe that starts a write transaction |
| txn_addr | input | 13 | Start address, sampled with `txn_open` |
| din_vld | input | 1 | One-cycle strobe: `din` carries a data byte |
| din | input | 8 | Data byte |
| txn_close | input | 1 | One-cycle strobe that ends the transaction |
| lock_in | input | 1 | Write inhibit, sampled with `txn_close` |
| mem_rd_data | input | 8 | Memory read data, valid the cycle after `mem_rd_en` |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 13 | Memory read address |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | 13 | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| busy | output | 1 | Hold period after a commit |

## Verification
The properties assume the memory returns read data exactly one cycle after a read request. They also assume each strobe lasts one cycle, that `din_vld` and `txn_close` never coincide, and that `HOLD_CYCLES` is at least the page size, so that a write burst always fits inside the hold period. The stimulus drives every strobe for a single cycle from the falling edge, and the memory model answers reads on the next rising edge. The bench is built with a hold time of 40 cycles. Stray strobes are sent only while the hold flag is high, which probes the refusal path without breaking these assumptions.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Transaction sequencing states
    typedef enum logic [1:0] {
        PCU_IDLE   = 2'd0,   // waiting for an accepted open strobe
        PCU_FILL   = 2'd1,   // page preload running, bytes accepted
        PCU_OPEN   = 2'd2,   // preload done, bytes accepted
        PCU_COMMIT = 2'd3    // page burst to memory
    } pcu_state_e;

endpackage

// File: rtl/pcu_page_buf.sv
module pcu_page_buf #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 32,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              host_we,
    input  logic [OFF_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_data,
    input  logic              fill_we,
    input  logic [OFF_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              own;   // slot already written by the host
        logic [DATA_W-1:0] val;
    } slot_t;

    logic [DATA_W-1:0] slot_val [PAGE_BYTES];

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        slot_t slot_d, slot_q;
        logic  hit_host, hit_fill;

        always_comb begin
            hit_host = host_we && (host_idx == OFF_W'(i));
            hit_fill = fill_we && (fill_idx == OFF_W'(i));
            slot_d   = slot_q;
            if (clr) begin
                slot_d.own = 1'b0;
            end else if (hit_host) begin
                slot_d.own = 1'b1;
                slot_d.val = host_data;
            end else if (hit_fill && !slot_q.own) begin
                slot_d.val = fill_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slot_val[i] = slot_q.val;
    end

    assign rd_data = slot_val[rd_idx];

endmodule

// File: rtl/pcu_hold_timer.sv
module pcu_hold_timer #(
    parameter int HOLD_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = CNT_W'(HOLD_CYCLES);
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = (tmr_q.cnt != '0);

endmodule

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
    import pcu_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int PAGE_BYTES = 32,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_open,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              din_vld,
    input  logic              txn_close,
    input  logic              lock_in,
    input  logic              busy,
    output logic              buf_clr,
    output logic              host_we,
    output logic [OFF_W-1:0]  host_idx,
    output logic              fill_we,
    output logic [OFF_W-1:0]  fill_idx,
    output logic [OFF_W-1:0]  burst_idx,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic              timer_load
);

    localparam int PAGE_W = ADDR_W - OFF_W;

    typedef struct packed {
        pcu_state_e       st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  ptr;
        logic [OFF_W:0]    rd_cnt;
        logic              fill_vld;
        logic [OFF_W-1:0]  fill_idx;
        logic              got;
        logic              close_pend;
        logic              lock_lat;
        logic [OFF_W-1:0]  wr_cnt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  rd_done;
    logic  take_byte;
    logic  close_eff;
    logic  lock_eff;

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.fill_vld = 1'b0;
        buf_clr        = 1'b0;
        timer_load     = 1'b0;
        mem_wr_en      = 1'b0;

        // top count bit set once all page offsets have been requested
        rd_done   = ctl_q.rd_cnt[OFF_W];
        mem_rd_en = (ctl_q.st == PCU_FILL) && !rd_done;

        take_byte = din_vld && !ctl_q.close_pend &&
                    ((ctl_q.st == PCU_FILL) || (ctl_q.st == PCU_OPEN));
        host_we   = take_byte;

        close_eff = ctl_q.close_pend || txn_close;
        lock_eff  = ctl_q.close_pend ? ctl_q.lock_lat : lock_in;

        case (ctl_q.st)
            PCU_IDLE: begin
                if (txn_open && !busy) begin
                    ctl_d.st         = PCU_FILL;
                    ctl_d.page       = txn_addr[ADDR_W-1:OFF_W];
                    ctl_d.ptr        = txn_addr[OFF_W-1:0];
                    ctl_d.rd_cnt     = '0;
                    ctl_d.got        = 1'b0;
                    ctl_d.close_pend = 1'b0;
                    ctl_d.lock_lat   = 1'b0;
                    buf_clr          = 1'b1;
                end
            end
            PCU_FILL: begin
                if (!rd_done) begin
                    ctl_d.rd_cnt   = ctl_q.rd_cnt + 1'b1;
                    ctl_d.fill_vld = 1'b1;
                    ctl_d.fill_idx = ctl_q.rd_cnt[OFF_W-1:0];
                end
                if (txn_close && !ctl_q.close_pend) begin
                    ctl_d.close_pend = 1'b1;
                    ctl_d.lock_lat   = lock_in;
                end
                if (rd_done && !ctl_q.fill_vld) begin
                    if (!close_eff) begin
                        ctl_d.st = PCU_OPEN;
                    end else if (ctl_q.got && !lock_eff) begin
                        ctl_d.st     = PCU_COMMIT;
                        ctl_d.wr_cnt = '0;
                        timer_load   = 1'b1;
                    end else begin
                        ctl_d.st = PCU_IDLE;
                    end
                end
            end
            PCU_OPEN: begin
                if (txn_close) begin
                    if (ctl_q.got && !lock_in) begin
                        ctl_d.st     = PCU_COMMIT;
                        ctl_d.wr_cnt = '0;
                        timer_load   = 1'b1;
                    end else begin
                        ctl_d.st = PCU_IDLE;
                    end
                end
            end
            PCU_COMMIT: begin
                mem_wr_en    = 1'b1;
                ctl_d.wr_cnt = ctl_q.wr_cnt + 1'b1;
                if (&ctl_q.wr_cnt) begin
                    ctl_d.st = PCU_IDLE;
                end
            end
            default: ctl_d.st = PCU_IDLE;
        endcase

        if (take_byte) begin
            ctl_d.ptr = ctl_q.ptr + 1'b1;   // wraps inside the page
            ctl_d.got = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= PCU_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign host_idx    = ctl_q.ptr;
    assign fill_we     = ctl_q.fill_vld;
    assign fill_idx    = ctl_q.fill_idx;
    assign burst_idx   = ctl_q.wr_cnt;
    assign mem_rd_addr = {ctl_q.page, ctl_q.rd_cnt[OFF_W-1:0]};
    assign mem_wr_addr = {ctl_q.page, ctl_q.wr_cnt};

endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit #(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 32,
    parameter int HOLD_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_open,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic              din_vld,
    input  logic [DATA_W-1:0] din,
    input  logic              txn_close,
    input  logic              lock_in,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              busy
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic             buf_clr;
    logic             host_we;
    logic [OFF_W-1:0] host_idx;
    logic             fill_we;
    logic [OFF_W-1:0] fill_idx;
    logic [OFF_W-1:0] burst_idx;
    logic             timer_load;

    pcu_ctrl #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .txn_open    (txn_open),
        .txn_addr    (txn_addr),
        .din_vld     (din_vld),
        .txn_close   (txn_close),
        .lock_in     (lock_in),
        .busy        (busy),
        .buf_clr     (buf_clr),
        .host_we     (host_we),
        .host_idx    (host_idx),
        .fill_we     (fill_we),
        .fill_idx    (fill_idx),
        .burst_idx   (burst_idx),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .timer_load  (timer_load)
    );

    pcu_page_buf #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .host_we   (host_we),
        .host_idx  (host_idx),
        .host_data (din),
        .fill_we   (fill_we),
        .fill_idx  (fill_idx),
        .fill_data (mem_rd_data),
        .rd_idx    (burst_idx),
        .rd_data   (mem_wr_data)
    );

    pcu_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .busy  (busy)
    );

endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BYTES  = 32,
    parameter int HOLD_CYCLES = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [31:0] blen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blen_q <= '0;
        end else begin
            blen_q <= busy ? blen_q + 1'b1 : '0;
        end
    end

    // R11
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R11
    no_read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !busy);

    // R8
    write_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> busy);

    // R8
    hold_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (blen_q < HOLD_CYCLES));

    // R8
    hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (blen_q == HOLD_CYCLES));

    // R5
    burst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !$past(mem_wr_en)) |-> (mem_wr_addr[OFF_W-1:0] == '0));

    // R5
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr == ADDR_W'($past(mem_wr_addr) + 1'b1)));

    // R2
    preload_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == ADDR_W'($past(mem_rd_addr) + 1'b1)));

    // R2
    preload_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !$past(mem_rd_en)) |-> (mem_rd_addr[OFF_W-1:0] == '0));

endmodule

bind page_commit_unit pcu_chk #(
    .ADDR_W      (ADDR_W),
    .PAGE_BYTES  (PAGE_BYTES),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr)
);

// File: tb/sim_page_commit_unit.sv
`timescale 1ns/1ps
module sim_page_commit_unit;

    localparam int HOLD = 40;
    localparam int PG   = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        txn_open, din_vld, txn_close, lock_in;
    logic [12:0] txn_addr;
    logic [7:0]  din;
    logic [7:0]  mem_rd_data;
    logic        mem_rd_en, mem_wr_en, busy;
    logic [12:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]  mem_wr_data;

    always #4 clk = ~clk;   // 125 MHz

    page_commit_unit #(.HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .txn_open(txn_open), .txn_addr(txn_addr),
        .din_vld(din_vld), .din(din), .txn_close(txn_close), .lock_in(lock_in),
        .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .busy(busy)
    );

    // sparse memory model, unwritten cells hold a computed pattern
    logic [7:0] shadow [int];

    function automatic logic [7:0] mem_get(int a);
        if (shadow.exists(a)) return shadow[a];
        return 8'((a * 37 + 11) ^ (a >> 5));
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_get(int'(mem_rd_addr));
        if (mem_wr_en) shadow[int'(mem_wr_addr)] = mem_wr_data;
    end

    typedef struct { int a; logic [7:0] d; } wexp_t;
    wexp_t wq[$];

    int  checks = 0, errors = 0;
    bit  rd_armed = 0;
    int  rd_base = 0, rd_next = 0;
    int  wcnt = 0, rises = 0, blen = 0;
    bit  busy_prev = 0, close_seen = 0, done = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected writes and checks reads and hold timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en || mem_wr_en)
                chk(!(mem_rd_en && mem_wr_en), "R11", "read and write together", 1, 0);
            if (mem_rd_en) begin
                if (!rd_armed || rd_next >= PG)
                    chk(0, "R9", "unexpected read", int'(mem_rd_addr), -1);
                else begin
                    chk(int'(mem_rd_addr) == rd_base + rd_next, "R2", "preload address",
                        int'(mem_rd_addr), rd_base + rd_next);
                    rd_next++;
                end
            end
            if (mem_wr_en) begin
                wcnt++;
                chk(close_seen, "R4", "write before close", 1, 0);
                chk(!rd_armed || rd_next == PG, "R10", "write before preload end", rd_next, PG);
                if (wq.size() == 0)
                    chk(0, "R6", "unexpected write", int'(mem_wr_addr), 0);
                else begin
                    wexp_t e;
                    e = wq.pop_front();
                    chk(int'(mem_wr_addr) == e.a && mem_wr_data == e.d, "R5", "commit byte",
                        int'({mem_wr_addr, mem_wr_data}), int'({13'(e.a), e.d}));
                end
            end
            if (busy && !busy_prev) begin
                rises++;
                chk(mem_wr_en, "R8", "hold start without write", int'(mem_wr_en), 1);
            end
            if (busy) blen++;
            if (!busy && busy_prev) begin
                chk(blen == HOLD, "R8", "hold length", blen, HOLD);
                blen = 0;
            end
            busy_prev = busy;
        end
    end

    task automatic send_txn(int addr, int n, int seed, int gap, bit lk_close, bit lk_after);
        int base = addr & ~(PG - 1);
        int off  = addr & (PG - 1);
        logic [7:0] pg [PG];
        for (int k = 0; k < PG; k++) pg[k] = mem_get(base + k);
        for (int i = 0; i < n; i++) pg[(off + i) % PG] = 8'(seed + i * 13);
        if (n > 0 && !lk_close)
            for (int k = 0; k < PG; k++) wq.push_back('{base + k, pg[k]});
        rd_base = base; rd_next = 0; rd_armed = 1; close_seen = 0;
        @(negedge clk); txn_open = 1; txn_addr = 13'(addr);
        @(negedge clk); txn_open = 0;
        repeat (gap) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            din_vld = 1; din = 8'(seed + i * 13);
            @(negedge clk);
        end
        din_vld = 0;
        lock_in = lk_close; txn_close = 1; close_seen = 1;
        @(negedge clk); txn_close = 0; lock_in = lk_after;
    endtask

    task automatic settle(string req);
        repeat (HOLD + 60) @(negedge clk);
        chk(wq.size() == 0, req, "writes missing", wq.size(), 0);
        chk(rd_next == PG, "R2", "preload count", rd_next, PG);
        chk(!busy, req, "hold still high", int'(busy), 0);
        rd_armed = 0;
        lock_in  = 0;
    endtask

    task automatic stray();
        txn_open = 1; txn_addr = 13'h0600;
        @(negedge clk); txn_open = 0; din_vld = 1; din = 8'hEE;
        @(negedge clk); din_vld = 0; txn_close = 1;
        @(negedge clk); txn_close = 0;
    endtask

    initial begin
        int w0, r0;
        rst_n = 0; txn_open = 0; txn_addr = '0; din_vld = 0; din = '0;
        txn_close = 0; lock_in = 0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_rd_en && !mem_wr_en, "R1", "reset outputs",
            int'({busy, mem_rd_en, mem_wr_en}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !mem_rd_en && !mem_wr_en, "R1", "idle after reset",
            int'({busy, mem_rd_en, mem_wr_en}), 0);

        // R5: single byte, close after preload finished
        send_txn(13'h0123, 1, 8'h5A, 40, 0, 0); settle("R5");
        // R2, R10: wrap at the page end, close during preload
        send_txn(13'h1FFE, 5, 8'h11, 0, 0, 0); settle("R10");
        // R3: 40 bytes, the last byte written to each slot wins
        send_txn(13'h0043, 40, 8'h77, 0, 0, 0); settle("R3");

        // R6: locked at close, nothing written, no hold
        w0 = wcnt; r0 = rises;
        send_txn(13'h0200, 4, 8'h22, 40, 1, 0); settle("R6");
        chk(wcnt == w0, "R6", "writes while locked", wcnt - w0, 0);
        chk(rises == r0, "R6", "hold while locked", rises - r0, 0);
        // R6: lock raised after close has no effect
        send_txn(13'h0300, 3, 8'h33, 40, 0, 1); settle("R6");

        // R7: address-only transaction, both close timings
        w0 = wcnt; r0 = rises;
        send_txn(13'h0400, 0, 0, 40, 0, 0); settle("R7");
        send_txn(13'h0420, 0, 0, 0, 0, 0); settle("R7");
        chk(wcnt == w0 && rises == r0, "R7", "commit without data", wcnt - w0, 0);

        // R9: strobes during the hold period are refused
        send_txn(13'h0500, 2, 8'h44, 40, 0, 0);
        while (!busy) @(negedge clk);
        repeat (3) @(negedge clk);
        stray();
        repeat (30) @(negedge clk);
        stray();
        settle("R9");
        chk(!shadow.exists(13'h0600), "R9", "refused byte reached memory", 1, 0);

        // R5: same page again, earlier commit content preserved
        send_txn(13'h012F, 2, 8'h99, 40, 0, 0); settle("R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule